// File: doc/BRIEF.md
# CAN Frame Transmit Serializer

This block places one classical CAN data or remote frame on a transmit line. A frame request carries the identifier, standard (11-bit) or extended (29-bit), a remote flag, the 4-bit length code and up to eight payload bytes. Once a request is accepted, the block builds the complete stuffed bit sequence in a local buffer, one raw bit per clock. The sequence covers start-of-frame through the CRC-15 checksum. The block then waits for the bus-idle permit and shifts the buffer out, holding each bit for a fixed number of clock-enable ticks. While it sends, it reads the receive line back in the middle of every bit. If it drives a recessive bit and reads it back dominant, it has lost arbitration or met a fault: it releases the line at once and reports a conflict.

The block also has an acknowledge mode. Once armed, it waits for a match pulse from an external receive path. It then drives a single dominant bit, releases the line and reports that the acknowledge is complete.

The frame request uses a valid/ready handshake. `frm_ready` is high only while the block is idle. A request is taken on a clock edge where `frm_valid` and `frm_ready` are both high. While `frm_valid` is high and `frm_ready` is low, the request fields must be held stable. A request offered while the block is busy is simply not taken.

Top module: `can_frame_tx`

## Requirements
- R1: Out of reset, `can_tx` is recessive (1), `busy` is 0 and `frm_ready` is 1. Whenever the block is not busy, `can_tx` is 1.
- R2: A standard frame (`frm_ext`=0) starts with this header, sent in order: a dominant start bit, ID[10:0] with the MSB first, the remote flag, a 0 identifier-extension bit, a 0 reserved bit, then the 4-bit length code MSB first. That is 19 bits.
- R3: An extended frame (`frm_ext`=1) starts with this header, sent in order: a start bit 0, ID[28:18], two 1 bits (substitute-remote and identifier-extension), ID[17:0], the remote flag, two 0 reserved bits, then the length code. That is 39 bits.
- R4: After the header and payload comes a 15-bit CRC, sent MSB first. It uses generator 0x4599 and initial value 0, and covers every bit from the start bit through the last payload bit.
- R5: After any five consecutive equal bits, from the start bit through the last CRC bit, a complementary stuff bit is inserted. Stuff bits take part in later runs. A stuff bit is also inserted after the last CRC bit when that bit completes a run of five. A single recessive delimiter follows, and it is never stuffed.
- R6: Payload byte k is `frm_data[8k+7:8k]`, sent MSB first, in the order k = 0, 1, 2 and so on. The number of bytes sent is 0 when the remote flag is set, and otherwise min(length code, 8). The length code is always sent as given, including values 9 to 15.
- R7: Each bit is held for `BIT_TICKS` cycles in which `tick` is high. Cycles with `tick` low do not advance the bit timer.
- R8: After a request is accepted, the start bit is not driven until `bus_idle` is high. Until then `can_tx` stays 1 and `busy` stays 1.
- R9: If the block drives a recessive bit and `can_rx` reads 0 at the sample point (tick count `BIT_TICKS`/2 of the bit), then on the next cycle `conflict` pulses for one cycle, `can_tx` returns to 1, the block goes idle and `done` does not pulse.
- R10: After the delimiter has been held for its full bit time, `done` pulses for one cycle, in the same cycle that `can_tx` returns to 1 and the block goes idle.
- R11: While the block is busy, `frm_ready` is 0 and a `frm_valid` request is not taken. No second frame follows.
- R12: A pulse on `ack_arm` while the block is idle arms the acknowledge mode, with `can_tx` held at 1. When `ack_match` arrives, `can_tx` is driven 0 for exactly one bit time. The line is then released, and `ack_done` pulses in the same cycle that the line returns to 1.
- R13: If `frm_valid` and `ack_arm` are both high in the same idle cycle, the frame is taken and the acknowledge request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Bit-timer clock enable |
| frm_valid | input | 1 | Frame request valid |
| frm_ready | output | 1 | Frame request accepted when high with valid |
| frm_ext | input | 1 | 1 selects a 29-bit identifier |
| frm_id | input | 29 | Identifier; bits [10:0] used for standard frames |
| frm_rtr | input | 1 | Remote request flag |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Payload, byte k in bits [8k+7:8k] |
| bus_idle | input | 1 | Permit to start driving a frame |
| ack_arm | input | 1 | Arm acknowledge mode |
| ack_match | input | 1 | Pulse that fires the acknowledge bit |
| can_rx | input | 1 | Receive line read-back |
| can_tx | output | 1 | Transmit line, 1 = recessive |
| busy | output | 1 | Block is not idle |
| done | output | 1 | Frame sent without conflict (pulse) |
| conflict | output | 1 | Recessive driven, dominant read (pulse) |
| ack_done | output | 1 | Acknowledge bit completed (pulse) |

## Verification
The assertions check several things on every cycle. The line is recessive whenever the block is idle. `done` and `conflict` never pulse together. Every conflict pulse follows a cycle with recessive driven and dominant read. Every acknowledge completion follows a dominant cycle, and the line is released when `done` pulses. Only the bench scenarios can show the exact content of the serialized frame: the header layouts, the CRC value, where stuff bits go, the clamping of the payload count, the bit timing under a gated tick, and the precedence between a frame request and an acknowledge request. The bench checks these by comparing the sampled line bit by bit against a sequence it computes itself.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  localparam int unsigned ID_W      = 29;
  localparam int unsigned DLC_W     = 4;
  localparam int unsigned MAX_BYTES = 8;
  localparam int unsigned PAY_W     = 8 * MAX_BYTES;
  localparam int unsigned CRC_W     = 15;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;
  localparam int unsigned STD_HDR   = 19;
  localparam int unsigned EXT_HDR   = 39;
  localparam int unsigned RAW_MAX   = EXT_HDR + PAY_W;
  localparam int unsigned RAW_LEN_W = $clog2(RAW_MAX + 1);
  localparam int unsigned STREAM_MAX = RAW_MAX + CRC_W;
  localparam int unsigned BUF_MAX   = STREAM_MAX + STREAM_MAX / 4 + 1;
  localparam int unsigned BUF_W     = $clog2(BUF_MAX + 1);
  localparam int unsigned RUN_LIMIT = 5;

  typedef enum logic [1:0] {PH_DATA, PH_CRC, PH_TAIL} build_phase_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BUILD, ST_WAIT_BUS, ST_SEND, ST_ACK_WAIT, ST_ACK_DRIVE
  } tx_state_t;

  function automatic logic [CRC_W-1:0] crc15_step(input logic [CRC_W-1:0] c,
                                                  input logic b);
    return {c[CRC_W-2:0], 1'b0} ^ ((c[CRC_W-1] ^ b) ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/can_header_pack.sv
module can_header_pack
  import can_tx_pkg::*;
(
  input  logic                 ext_i,
  input  logic [ID_W-1:0]      id_i,
  input  logic                 rtr_i,
  input  logic [DLC_W-1:0]     dlc_i,
  input  logic [PAY_W-1:0]     data_i,
  output logic [RAW_MAX-1:0]   raw_o,
  output logic [RAW_LEN_W-1:0] len_o
);
  localparam int unsigned STD_PAD = EXT_HDR - STD_HDR;

  logic [PAY_W-1:0]   pay_seq;
  logic [STD_HDR-1:0] hdr_std;
  logic [EXT_HDR-1:0] hdr_ext;
  logic [DLC_W-1:0]   nbytes;

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_byte
    assign pay_seq[PAY_W-1-8*k -: 8] = data_i[8*k +: 8];
  end

  assign hdr_std = {1'b0, id_i[10:0], rtr_i, 1'b0, 1'b0, dlc_i};
  assign hdr_ext = {1'b0, id_i[28:18], 1'b1, 1'b1, id_i[17:0], rtr_i, 2'b00, dlc_i};

  always_comb begin
    if (rtr_i)                            nbytes = '0;
    else if (dlc_i > DLC_W'(MAX_BYTES))   nbytes = DLC_W'(MAX_BYTES);
    else                                  nbytes = dlc_i;
  end

  assign raw_o = ext_i ? {hdr_ext, pay_seq} : {hdr_std, pay_seq, {STD_PAD{1'b0}}};
  assign len_o = (ext_i ? RAW_LEN_W'(EXT_HDR) : RAW_LEN_W'(STD_HDR))
               + RAW_LEN_W'({nbytes, 3'b000});
endmodule

// File: rtl/can_stuff_builder.sv
module can_stuff_builder
  import can_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [RAW_MAX-1:0]   raw_i,
  input  logic [RAW_LEN_W-1:0] len_i,
  output logic                 fin_o,
  output logic [BUF_MAX-1:0]   bits_o,
  output logic [BUF_W-1:0]     count_o
);
  logic [RAW_MAX-1:0]   raw_q;
  logic [RAW_LEN_W-1:0] left_q;
  logic [CRC_W-1:0]     crc_q;
  logic [3:0]           crc_left_q;
  logic [2:0]           run_q;
  logic                 last_q;
  logic                 active_q;
  logic                 fin_q;
  build_phase_t         phase_q;
  logic [BUF_MAX-1:0]   bits_q;
  logic [BUF_W-1:0]     wr_q;
  logic                 stuff_now;
  logic                 cur_bit;

  always_comb begin
    stuff_now = (run_q == 3'(RUN_LIMIT));
    if (stuff_now) cur_bit = ~last_q;
    else begin
      case (phase_q)
        PH_DATA: cur_bit = raw_q[RAW_MAX-1];
        PH_CRC:  cur_bit = crc_q[CRC_W-1];
        default: cur_bit = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0; left_q <= '0; crc_q <= '0; crc_left_q <= '0;
      run_q <= '0; last_q <= 1'b1; active_q <= 1'b0; fin_q <= 1'b0;
      phase_q <= PH_DATA; bits_q <= '0; wr_q <= '0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        raw_q <= raw_i; left_q <= len_i; crc_q <= '0;
        run_q <= '0; last_q <= 1'b1; wr_q <= '0;
        phase_q <= PH_DATA; active_q <= 1'b1;
      end else if (active_q) begin
        bits_q[wr_q] <= cur_bit;
        wr_q   <= wr_q + BUF_W'(1);
        last_q <= cur_bit;
        if (stuff_now) begin
          run_q <= 3'd1;
        end else begin
          run_q <= (cur_bit == last_q) ? run_q + 3'd1 : 3'd1;
          case (phase_q)
            PH_DATA: begin
              crc_q  <= crc15_step(crc_q, cur_bit);
              raw_q  <= raw_q << 1;
              left_q <= left_q - RAW_LEN_W'(1);
              if (left_q == RAW_LEN_W'(1)) begin
                phase_q    <= PH_CRC;
                crc_left_q <= 4'(CRC_W);
              end
            end
            PH_CRC: begin
              crc_q      <= crc_q << 1;
              crc_left_q <= crc_left_q - 4'd1;
              if (crc_left_q == 4'd1) phase_q <= PH_TAIL;
            end
            default: begin
              active_q <= 1'b0;
              fin_q    <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign fin_o   = fin_q;
  assign bits_o  = bits_q;
  assign count_o = wr_q;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int unsigned BIT_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  output logic sample_o,
  output logic end_o
);
  localparam int unsigned CNT_W     = $clog2(BIT_TICKS);
  localparam int unsigned SAMPLE_AT = BIT_TICKS / 2;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!en_i)             cnt_q <= '0;
    else if (tick_i) begin
      if (cnt_q == CNT_W'(BIT_TICKS - 1)) cnt_q <= '0;
      else                                cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign sample_o = en_i && tick_i && (cnt_q == CNT_W'(SAMPLE_AT));
  assign end_o    = en_i && tick_i && (cnt_q == CNT_W'(BIT_TICKS - 1));
endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx
  import can_tx_pkg::*;
#(
  parameter int unsigned BIT_TICKS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic              frm_ext,
  input  logic [ID_W-1:0]   frm_id,
  input  logic              frm_rtr,
  input  logic [DLC_W-1:0]  frm_dlc,
  input  logic [PAY_W-1:0]  frm_data,
  input  logic              bus_idle,
  input  logic              ack_arm,
  input  logic              ack_match,
  input  logic              can_rx,
  output logic              can_tx,
  output logic              busy,
  output logic              done,
  output logic              conflict,
  output logic              ack_done
);
  tx_state_t            state_q;
  logic [RAW_MAX-1:0]   raw;
  logic [RAW_LEN_W-1:0] raw_len;
  logic                 load;
  logic                 build_fin;
  logic [BUF_MAX-1:0]   stream;
  logic [BUF_W-1:0]     stream_len;
  logic [BUF_W-1:0]     idx_q;
  logic                 tx_q, done_q, conflict_q, ack_done_q;
  logic                 timer_en, bit_sample, bit_end;

  assign load     = frm_valid && (state_q == ST_IDLE);
  assign timer_en = (state_q == ST_SEND) || (state_q == ST_ACK_DRIVE);

  can_header_pack u_pack (
    .ext_i(frm_ext), .id_i(frm_id), .rtr_i(frm_rtr), .dlc_i(frm_dlc),
    .data_i(frm_data), .raw_o(raw), .len_o(raw_len)
  );

  can_stuff_builder u_build (
    .clk(clk), .rst_n(rst_n), .load_i(load), .raw_i(raw), .len_i(raw_len),
    .fin_o(build_fin), .bits_o(stream), .count_o(stream_len)
  );

  can_bit_timer #(.BIT_TICKS(BIT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .en_i(timer_en), .tick_i(tick),
    .sample_o(bit_sample), .end_o(bit_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; idx_q <= '0; tx_q <= 1'b1;
      done_q <= 1'b0; conflict_q <= 1'b0; ack_done_q <= 1'b0;
    end else begin
      done_q <= 1'b0; conflict_q <= 1'b0; ack_done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (frm_valid)    state_q <= ST_BUILD;
          else if (ack_arm) state_q <= ST_ACK_WAIT;
        end
        ST_BUILD: if (build_fin) state_q <= ST_WAIT_BUS;
        ST_WAIT_BUS: begin
          if (bus_idle) begin
            state_q <= ST_SEND;
            idx_q   <= '0;
            tx_q    <= stream[0];
          end
        end
        ST_SEND: begin
          if (bit_sample && tx_q && !can_rx) begin
            conflict_q <= 1'b1;
            tx_q       <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (bit_end) begin
            if (idx_q + BUF_W'(1) == stream_len) begin
              done_q  <= 1'b1;
              tx_q    <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q <= idx_q + BUF_W'(1);
              tx_q  <= stream[idx_q + BUF_W'(1)];
            end
          end
        end
        ST_ACK_WAIT: begin
          if (ack_match) begin
            tx_q    <= 1'b0;
            state_q <= ST_ACK_DRIVE;
          end
        end
        ST_ACK_DRIVE: begin
          if (bit_end) begin
            tx_q       <= 1'b1;
            ack_done_q <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign frm_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign can_tx    = tx_q;
  assign done      = done_q;
  assign conflict  = conflict_q;
  assign ack_done  = ack_done_q;
endmodule

// File: rtl/can_frame_tx_checker.sv
module can_frame_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic can_tx,
  input logic can_rx,
  input logic busy,
  input logic done,
  input logic conflict,
  input logic ack_done
);
  assert_idle_recessive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> can_tx);

  assert_single_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && conflict));

  assert_conflict_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> ($past(can_tx) && !$past(can_rx)));

  assert_conflict_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (can_tx && !busy));

  assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (can_tx && !busy));

  assert_ack_dominant_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_done |-> (!$past(can_tx) && can_tx));
endmodule

bind can_frame_tx can_frame_tx_checker u_check (
  .clk(clk), .rst_n(rst_n), .can_tx(can_tx), .can_rx(can_rx), .busy(busy),
  .done(done), .conflict(conflict), .ack_done(ack_done)
);

// File: tb/test_can_frame_tx.sv
`timescale 1ns/1ps
module test_can_frame_tx;
  localparam int BT = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, half_rate = 1'b0;
  logic frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [63:0] frm_data = '0;
  logic bus_idle = 1'b1, ack_arm = 1'b0, ack_match = 1'b0, force_dom = 1'b0;
  logic frm_ready, can_rx, can_tx, busy, done, conflict, ack_done;

  int checks = 0, fails = 0;
  bit exp_bits [0:255];
  int exp_len;
  bit cap [0:4095];
  int t0, done_cyc;

  always #2.5 clk = ~clk;
  always @(negedge clk) tick <= half_rate ? ~tick : 1'b1;
  assign can_rx = can_tx & ~force_dom;

  can_frame_tx #(.BIT_TICKS(BT)) i_can_frame_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .frm_valid(frm_valid),
    .frm_ready(frm_ready), .frm_ext(frm_ext), .frm_id(frm_id),
    .frm_rtr(frm_rtr), .frm_dlc(frm_dlc), .frm_data(frm_data),
    .bus_idle(bus_idle), .ack_arm(ack_arm), .ack_match(ack_match),
    .can_rx(can_rx), .can_tx(can_tx), .busy(busy), .done(done),
    .conflict(conflict), .ack_done(ack_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected line sequence computed from the requirements
  task automatic model(input bit ext, input logic [28:0] id, input bit rtr,
                       input logic [3:0] dlc, input logic [63:0] data);
    bit raw [0:127];
    int n = 0, nb, run = 0;
    logic [14:0] crc = '0;
    bit last = 1'b1, fb;
    raw[n++] = 1'b0;
    if (ext) begin
      for (int i = 28; i >= 18; i--) raw[n++] = id[i];
      raw[n++] = 1'b1; raw[n++] = 1'b1;
      for (int i = 17; i >= 0; i--) raw[n++] = id[i];
      raw[n++] = rtr; raw[n++] = 1'b0; raw[n++] = 1'b0;
    end else begin
      for (int i = 10; i >= 0; i--) raw[n++] = id[i];
      raw[n++] = rtr; raw[n++] = 1'b0; raw[n++] = 1'b0;
    end
    for (int i = 3; i >= 0; i--) raw[n++] = dlc[i];
    nb = rtr ? 0 : (dlc > 8 ? 8 : int'(dlc));
    for (int b = 0; b < nb; b++)
      for (int i = 7; i >= 0; i--) raw[n++] = data[8*b + i];
    for (int i = 0; i < n; i++) begin
      fb = crc[14] ^ raw[i];
      crc = {crc[13:0], 1'b0};
      if (fb) crc = crc ^ 15'h4599;
    end
    for (int i = 14; i >= 0; i--) raw[n++] = crc[i];
    exp_len = 0;
    for (int i = 0; i < n; i++) begin
      if (run == 5) begin exp_bits[exp_len++] = ~last; last = ~last; run = 1; end
      run = (raw[i] == last) ? run + 1 : 1;
      last = raw[i];
      exp_bits[exp_len++] = raw[i];
    end
    if (run == 5) exp_bits[exp_len++] = ~last;
    exp_bits[exp_len++] = 1'b1;
  endtask

  task automatic run_frame(input bit ext, input logic [28:0] id, input bit rtr,
                           input logic [3:0] dlc, input logic [63:0] data,
                           input string req, input int hold_idle,
                           input bit poke, input bit arm_too);
    int cyc = 0, span, mism = 0, first_bad = -1;
    bit got_done = 0, got_conf = 0, ok_hold = 1, ok_poke = 1;
    model(ext, id, rtr, dlc, data);
    span = BT * (half_rate ? 2 : 1);
    @(negedge clk);
    frm_ext = ext; frm_id = id; frm_rtr = rtr; frm_dlc = dlc; frm_data = data;
    frm_valid = 1'b1; ack_arm = arm_too;
    chk(frm_ready, "R11", "ready before request", frm_ready, 1);
    @(negedge clk);
    frm_valid = 1'b0; ack_arm = 1'b0;
    if (hold_idle > 0) begin
      repeat (hold_idle) begin
        @(negedge clk);
        if (!can_tx || !busy) ok_hold = 0;
      end
      chk(ok_hold, "R8", "line held until bus idle", {can_tx, busy}, 2'b11);
      bus_idle = 1'b1;
    end
    t0 = -1; done_cyc = -1;
    while (cyc < 4000 && !got_done && !got_conf) begin
      @(negedge clk);
      if (poke && t0 >= 0 && cyc == t0 + 40) begin
        frm_valid = 1'b1; frm_id = ~id; frm_dlc = 4'd1;
      end
      if (poke && t0 >= 0 && cyc == t0 + 60) frm_valid = 1'b0;
      if (frm_valid && frm_ready) ok_poke = 0;
      cap[cyc] = can_tx;
      if (t0 < 0 && !can_tx) t0 = cyc;
      if (done) begin got_done = 1; done_cyc = cyc; end
      if (conflict) got_conf = 1;
      cyc++;
    end
    frm_valid = 1'b0;
    for (int k = 0; k < exp_len; k++) begin
      if (t0 < 0 || cap[t0 + k*span + span/2] !== exp_bits[k]) begin
        mism++;
        if (first_bad < 0) first_bad = k;
      end
    end
    chk(mism == 0 && t0 >= 0, req, $sformatf("bit sequence (first bad bit %0d)", first_bad),
        mism, 0);
    chk(got_done && !got_conf, "R10", "done pulse without conflict", {got_done, got_conf}, 2'b10);
    if (!half_rate)
      chk(done_cyc == t0 + exp_len*BT && cap[done_cyc] == 1'b1, "R7 R10",
          "done cycle", done_cyc, t0 + exp_len*BT);
    if (poke) begin
      chk(ok_poke, "R11", "request taken while busy", ok_poke, 1);
      ok_poke = 1;
      repeat (100) begin @(negedge clk); if (!can_tx || busy) ok_poke = 0; end
      chk(ok_poke, "R11", "no second frame after busy poke", ok_poke, 1);
    end
    if (arm_too) begin
      bit ok_arm = 1;
      @(negedge clk); ack_match = 1'b1;
      @(negedge clk); ack_match = 1'b0;
      repeat (3*BT) begin @(negedge clk); if (!can_tx || busy || ack_done) ok_arm = 0; end
      chk(ok_arm, "R13", "ack request dropped when frame wins", ok_arm, 1);
    end
  endtask

  task automatic run_conflict();
    int cyc = 0, k = 1, conf_cyc = -1;
    bit ok_after = 1;
    model(1'b0, 29'h5A3, 1'b0, 4'd2, 64'h00000000_0000C3A5);
    @(negedge clk);
    frm_ext = 0; frm_id = 29'h5A3; frm_rtr = 0; frm_dlc = 4'd2;
    frm_data = 64'h0000C3A5; frm_valid = 1'b1;
    @(negedge clk); frm_valid = 1'b0;
    while (can_tx && cyc < 2000) begin @(negedge clk); cyc++; end
    t0 = cyc;
    while (exp_bits[k] != 1'b1) k++;
    while (cyc < t0 + k*BT) begin @(negedge clk); cyc++; end
    force_dom = 1'b1;
    for (int j = 0; j < 2*BT; j++) begin
      @(negedge clk); cyc++;
      if (conflict && conf_cyc < 0) begin
        conf_cyc = cyc;
        chk(can_tx == 1'b1, "R9", "line released on conflict", can_tx, 1);
      end
    end
    force_dom = 1'b0;
    chk(conf_cyc == t0 + k*BT + BT/2 + 1, "R9", "conflict cycle", conf_cyc,
        t0 + k*BT + BT/2 + 1);
    repeat (50) begin @(negedge clk); if (busy || done || !can_tx) ok_after = 0; end
    chk(ok_after, "R9", "idle and no done after conflict", ok_after, 1);
  endtask

  task automatic run_ack();
    int n = 0;
    bit ok_wait = 1, seen = 0;
    @(negedge clk); ack_arm = 1'b1;
    @(negedge clk); ack_arm = 1'b0;
    repeat (10) begin @(negedge clk); if (!can_tx || !busy || frm_ready) ok_wait = 0; end
    chk(ok_wait, "R12", "armed wait holds recessive", ok_wait, 1);
    ack_match = 1'b1;
    @(negedge clk); ack_match = 1'b0;
    for (int j = 0; j < 100 && !seen; j++) begin
      if (ack_done) begin seen = 1; chk(can_tx, "R12", "line released at ack_done", can_tx, 1); end
      else begin
        if (!can_tx) n++;
        @(negedge clk);
      end
    end
    chk(seen && n == BT, "R12", "dominant ack length", n, BT);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(can_tx == 1 && busy == 0 && frm_ready == 1 && done == 0, "R1",
        "reset state", {can_tx, busy, frm_ready, done}, 4'b1010);

    for (int e = 0; e < 2; e++)
      for (int r = 0; r < 2; r++)
        for (int d = 0; d < 11; d++) begin
          logic [63:0] pat;
          logic [3:0] dl = (d == 10) ? 4'd15 : 4'(d);
          logic [28:0] idv = e ? 29'(32'h1ABCDE5 + d*32'h10F3) : 29'(11'h2C5 + d*7);
          for (int b = 0; b < 8; b++) pat[8*b +: 8] = 8'(b*17 + d*29 + e*5 + r);
          run_frame(e[0], idv, r[0], dl, pat,
                    e ? "R3 R4 R5 R6" : "R2 R4 R5 R6", 0, 0, 0);
        end

    run_frame(1'b0, 29'h0, 1'b0, 4'd8, 64'h0, "R5 all-dominant", 0, 0, 0);
    run_frame(1'b1, 29'h1FFFFFFF, 1'b0, 4'd8, {64{1'b1}}, "R5 all-recessive", 0, 0, 0);

    half_rate = 1'b1;
    run_frame(1'b0, 29'h3F0, 1'b0, 4'd3, 64'h00_0000_0055AA0F, "R7 gated tick", 0, 0, 0);
    half_rate = 1'b0;
    @(negedge clk); @(negedge clk);

    bus_idle = 1'b0;
    run_frame(1'b0, 29'h123, 1'b0, 4'd1, 64'h7E, "R8", 60, 0, 0);
    run_frame(1'b0, 29'h456, 1'b0, 4'd4, 64'h0F0F_0F0F, "R11", 0, 1, 0);
    run_frame(1'b0, 29'h7FF, 1'b1, 4'd2, 64'h0, "R13", 0, 0, 1);

    run_conflict();
    run_ack();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule